// File: doc/BRIEF.md
# Line Voltage Sag Detector

This block watches a stream of signed line-voltage samples and raises an alarm when the amplitude of the line drops for a programmable number of half-line cycles in a row. Each accepted sample updates a polarity tracker. A change of polarity marks a zero crossing, which ends one half cycle and starts the next. The block keeps the largest magnitude seen during the current half cycle. When a crossing closes that half cycle, the peak is compared against a programmable level.

Half cycles whose peak falls below the level are counted. When the count reaches the programmed duration, the active-low sag output is driven low. The first half cycle whose peak reaches the level clears the count and releases the output. The polarity state is also driven out as a zero-crossing output that toggles at every crossing, so a host can time the line period from it. A hysteresis parameter, zero by default, keeps noise near zero from producing false crossings.

Top module: `sag_detector`

## Requirements
- R1: After reset, `sag_n` is 1, `zx` is 0, the half-cycle peak is 0 and the low-half-cycle count is 0.
- R2: On a valid sample, `zx` goes from 0 to 1 when the sample is greater than +HYST. It goes from 1 to 0 when the sample is less than -HYST. Otherwise it holds its value. Samples are two's complement. `zx` shows the new value from the clock edge that accepts the sample.
- R3: A cycle with `smp_valid` low changes neither `zx` nor `sag_n`, whatever the value on `smp_data`.
- R4: The peak of a half cycle is the largest absolute value from the sample that opened it up to the last sample before the next crossing. That peak is judged at the crossing that closes the half cycle.
- R5: A closed half cycle is low when its peak is less than `sag_level`, both taken as unsigned. `sag_n` falls at the crossing that closes the Nth consecutive low half cycle, where N = `sag_cycles`. A value of 0 acts as 1.
- R6: A closed half cycle whose peak is greater than or equal to `sag_level` sets `sag_n` to 1 and clears the count at that crossing. A peak exactly equal to the level counts as not low.
- R7: If fewer than N low half cycles are followed by a half cycle that is not low, no sag is flagged, and counting starts again from zero.
- R8: The low-half-cycle count saturates at 2^CW-1. A sag longer than that keeps `sag_n` low, with no wrap-around.
- R9: With `sag_level` = 0, no half cycle is ever low, so `sag_n` stays 1.
- R10: The most negative sample value has a magnitude of 2^(W-1). It is compared correctly against `sag_level`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Marks the sample on `smp_data` as valid this cycle |
| smp_data | input | W | Signed line-voltage sample |
| sag_level | input | W | Unsigned peak threshold for a low half cycle |
| sag_cycles | input | CW | Number of consecutive low half cycles that qualifies a sag |
| zx | output | 1 | Zero-crossing output; high during positive half cycles |
| sag_n | output | 1 | Active-low sag flag |

## Verification
The hardest state to reach is the saturated counter: more than 255 consecutive low half cycles are needed before the limit matters. The bench drives 300 short two-sample low half cycles, and only then drives one half cycle above the level. Any wrap of the count would briefly release `sag_n`, which the per-sample scoreboard catches. Boundary peaks are also driven: exactly at the level, and the most negative sample against levels on both sides of 32768. Idle cycles carry large opposite-sign data to show that unqualified samples are ignored.

// File: rtl/sag_pkg.sv
package sag_pkg;
  // absolute value of a sign-extended sample
  function automatic int mag_of(int s);
    return (s < 0) ? -s : s;
  endfunction

  // polarity change with a dead band of +/-h around zero
  function automatic logic crosses(logic pol, int s, int h);
    return pol ? (s < -h) : (s > h);
  endfunction

  // next value of the consecutive-low counter
  function automatic int count_step(int c, int cmax, logic low);
    if (!low) return 0;
    return (c >= cmax) ? cmax : c + 1;
  endfunction

  // count has reached the qualifying duration (0 treated as 1)
  function automatic logic reached(int c, int target);
    return c >= ((target < 1) ? 1 : target);
  endfunction
endpackage

// File: rtl/sag_polarity.sv
module sag_polarity #(
  parameter int W    = 16,
  parameter int HYST = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp_data,
  output logic                pol,
  output logic                xing
);
  import sag_pkg::*;

  assign xing = smp_valid && crosses(pol, int'(smp_data), HYST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pol <= 1'b0;
    else if (xing) pol <= ~pol;
  end
endmodule

// File: rtl/sag_peak.sv
module sag_peak #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic         xing,
  input  logic [W-1:0] mag,
  output logic [W-1:0] peak
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      peak <= '0;
    else if (smp_valid) begin
      if (xing)            peak <= mag;
      else if (mag > peak) peak <= mag;
    end
  end
endmodule

// File: rtl/sag_qualify.sv
module sag_qualify #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xing,
  input  logic [W-1:0]  peak,
  input  logic [W-1:0]  sag_level,
  input  logic [CW-1:0] sag_cycles,
  output logic          low_hc,
  output logic [CW-1:0] cnt,
  output logic          sag_n
);
  import sag_pkg::*;
  localparam int CMAX = (1 << CW) - 1;

  int cnt_nxt;

  assign low_hc = peak < sag_level;

  always_comb cnt_nxt = count_step(int'(cnt), CMAX, low_hc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sag_n <= 1'b1;
    end else if (xing) begin
      cnt   <= CW'(cnt_nxt);
      sag_n <= !(low_hc && reached(cnt_nxt, int'(sag_cycles)));
    end
  end
endmodule

// File: rtl/sag_detector.sv
module sag_detector #(
  parameter int W    = 16,
  parameter int CW   = 8,
  parameter int HYST = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp_data,
  input  logic [W-1:0]        sag_level,
  input  logic [CW-1:0]       sag_cycles,
  output logic                zx,
  output logic                sag_n
);
  import sag_pkg::*;

  logic          xing;     // crossing accepted this cycle
  logic [W-1:0]  mag;      // magnitude of current sample
  logic [W-1:0]  hc_peak;  // running peak; closed-half-cycle peak when xing
  logic          low_hc;   // closing half cycle is below level
  logic [CW-1:0] cnt;      // consecutive low half cycles

  assign mag = W'(mag_of(int'(smp_data)));

  sag_polarity #(.W(W), .HYST(HYST)) u_pol (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .pol(zx), .xing(xing)
  );

  sag_peak #(.W(W)) u_peak (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .xing(xing),
    .mag(mag), .peak(hc_peak)
  );

  sag_qualify #(.W(W), .CW(CW)) u_qual (
    .clk(clk), .rst_n(rst_n), .xing(xing), .peak(hc_peak),
    .sag_level(sag_level), .sag_cycles(sag_cycles),
    .low_hc(low_hc), .cnt(cnt), .sag_n(sag_n)
  );
endmodule

// File: rtl/sag_detector_chk.sv
module sag_detector_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          xing,
  input logic          low_hc,
  input logic          zx,
  input logic          sag_n,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  assert_zx_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xing |=> (zx != $past(zx)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(zx) && $stable(sag_n) && $stable(cnt)));

  assert_fall_at_low_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sag_n) |-> $past(xing && low_hc));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xing && !low_hc) |=> (sag_n && cnt == '0));

  assert_cnt_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xing && low_hc && cnt == CMAX) |=> (cnt == CMAX && !sag_n));
endmodule

bind sag_detector sag_detector_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .xing(xing),
  .low_hc(low_hc), .zx(zx), .sag_n(sag_n), .cnt(cnt)
);

// File: tb/sag_detector_tb.sv
module sag_detector_tb;
  localparam int W = 16;
  localparam int CW = 8;
  localparam int HYST = 0;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [W-1:0] smp_data = '0;
  logic [W-1:0] sag_level = '0;
  logic [CW-1:0] sag_cycles = '0;
  logic zx, sag_n;

  always #10 clk = ~clk;  // 50 MHz

  sag_detector #(.W(W), .CW(CW), .HYST(HYST)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .sag_level(sag_level), .sag_cycles(sag_cycles), .zx(zx), .sag_n(sag_n)
  );

  typedef struct { logic zx; logic sag_n; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference state, from the requirements
  logic m_pol = 0, m_sag = 1;
  int m_peak = 0, m_cnt = 0;

  task automatic model(int s);
    int a = (s < 0) ? -s : s;
    bit cr = m_pol ? (s < -HYST) : (s > HYST);
    if (cr) begin
      if (m_peak < int'(sag_level)) begin
        m_cnt = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
        if (m_cnt >= ((sag_cycles == 0) ? 1 : int'(sag_cycles))) m_sag = 0;
      end else begin
        m_cnt = 0;
        m_sag = 1;
      end
      m_pol = ~m_pol;
      m_peak = a;
    end else if (a > m_peak) m_peak = a;
  endtask

  task automatic sample(int v, string tag);
    exp_t e;
    @(negedge clk);
    smp_valid = 1;
    smp_data = W'(v);
    model(v);
    e.zx = m_pol; e.sag_n = m_sag; e.tag = tag;
    @(posedge clk);
    q.push_back(e);
  endtask

  task automatic idle(int v, string tag);
    exp_t e;
    @(negedge clk);
    smp_valid = 0;
    smp_data = W'(v);
    e.zx = m_pol; e.sag_n = m_sag; e.tag = tag;
    @(posedge clk);
    q.push_back(e);
  endtask

  // one half cycle: middle sample at amp, others at amp/2
  task automatic half(int sgn, int amp, int len, string tag);
    for (int i = 0; i < len; i++) begin
      int v = (i == len / 2) ? amp : ((amp / 2 < 1) ? 1 : amp / 2);
      sample(sgn * v, tag);
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compare design outputs against queued expectations
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(zx === e.zx, {e.tag, " zx"}, int'(zx), int'(e.zx));
        chk(sag_n === e.sag_n, {e.tag, " sag_n"}, int'(sag_n), int'(e.sag_n));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sag_n === 1'b1, "R1 sag_n", int'(sag_n), 1);
    chk(zx === 1'b0, "R1 zx", int'(zx), 0);
    sag_level = 16'd1000;
    sag_cycles = 8'd3;
    rst_n = 1;

    // normal line, zeros do not cross (R2, R4)
    for (int k = 0; k < 4; k++) half((k % 2) ? -1 : 1, 2000, 4, "R2");
    sample(0, "R2"); sample(0, "R2");
    half(1, 1500, 3, "R4");
    half(-1, 1200, 5, "R4");

    // two low then one normal: no sag (R7)
    half(1, 500, 3, "R7"); half(-1, 500, 3, "R7"); half(1, 2000, 3, "R7");
    half(-1, 500, 3, "R7"); half(1, 2000, 3, "R7");

    // three low qualifies, high releases (R5, R6)
    half(-1, 400, 3, "R5"); half(1, 400, 3, "R5"); half(-1, 400, 3, "R5");
    half(1, 2000, 3, "R5");
    chk(sag_n === 1'b0, "R5 direct", int'(sag_n), 0);
    half(-1, 2000, 3, "R6");
    chk(sag_n === 1'b1, "R6 direct", int'(sag_n), 1);

    // peak exactly at level is not low (R6)
    for (int k = 0; k < 5; k++) half((k % 2) ? 1 : -1, 1000, 3, "R6");
    // peak just below level is low
    for (int k = 0; k < 4; k++) half((k % 2) ? 1 : -1, 999, 3, "R5");

    // invalid cycles ignored (R3)
    half(1, 2000, 3, "R3");
    idle(-30000, "R3"); idle(30000, "R3"); idle(-30000, "R3");
    half(-1, 2000, 3, "R3");
    idle(-30000, "R3");

    // duration 0 acts as 1 (R5)
    sag_cycles = 8'd0;
    half(1, 3000, 3, "R5"); half(-1, 10, 3, "R5"); half(1, 3000, 3, "R5");
    half(-1, 3000, 3, "R5");
    sag_cycles = 8'd3;

    // saturation over a long sag (R8)
    for (int k = 0; k < 300; k++) half((k % 2) ? -1 : 1, 100, 2, "R8");
    chk(sag_n === 1'b0, "R8 direct", int'(sag_n), 0);
    half(1, 2000, 3, "R8"); half(-1, 2000, 3, "R8");
    chk(sag_n === 1'b1, "R8 release", int'(sag_n), 1);

    // zero level never sags (R9)
    sag_level = 16'd0;
    for (int k = 0; k < 6; k++) half((k % 2) ? -1 : 1, 5, 2, "R9");

    // most negative sample (R10)
    sag_level = 16'd32768;
    sag_cycles = 8'd1;
    half(1, 32767, 3, "R10");
    half(-1, 32768, 3, "R10");
    half(1, 32767, 3, "R10");
    sag_level = 16'd32769;
    half(-1, 32768, 3, "R10");
    half(1, 100, 3, "R10");

    smp_valid = 0;
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "drain", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule